// File: doc/BRIEF.md
# Recursive Crosswise Multiplier

This block multiplies two unsigned operands and returns their full-width product. There are no registers in it. The product follows the operands through combinational logic alone, so it needs no clock, reset or handshake. A surrounding pipeline registers the operands and the product wherever its timing needs them.

The datapath is a recursion. The smallest cell multiplies two 2-bit values with four AND gates and two half adders:
- The LSB is the AND of the two operand LSBs.
- The two cross terms are summed.
- Their carry is added to the AND of the two MSBs.

Every wider level splits each operand into a high and a low half and builds four half-width products. Three ripple-carry adders at that level merge the four products:
- The first adds the two cross products.
- The second adds the upper half of the low-by-low product to that sum.
- The third adds the high-by-high product.

The lower half of the low-by-low product goes straight to the output with no adder on the way. The operand width is a parameter; it must be a power of two and at least 2.

Top module: `vc_mult16`

## Requirements
- R1: For every pair of unsigned operands, `product` equals the arithmetic product `op_a * op_b` in 2·WIDTH bits.
- R2: The block holds no state: a change on either operand shows at `product` after propagation only, with no clock edge, and the result does not depend on earlier operand values.
- R3: When either operand is zero, `product` is zero.
- R4: When one operand is 1, `product` equals the other operand zero-extended to 2·WIDTH bits.
- R5: Bit 0 of `product` is the AND of bit 0 of `op_a` and bit 0 of `op_b`.
- R6: With both operands at their maximum (all ones), `product` is 2^(2·WIDTH) − 2^(WIDTH+1) + 1, which is 0xFFFE0001 for WIDTH = 16.
- R7: 325 × 512 gives 166400, and 24 × 24 gives 576.
- R8: When both operands are below 2^(WIDTH/2), the upper WIDTH bits of `product` are zero and the lower bits hold the exact product.
- R9: Swapping the two operands leaves `product` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH (16) | Unsigned multiplicand |
| op_b | input | WIDTH (16) | Unsigned multiplier |
| product | output | 2·WIDTH (32) | Unsigned product of op_a and op_b |

## Verification
The bench drives every pair of 8-bit operands. At that size every low-by-low sub-product is exercised across its whole range. A merge adder that drops the carry out of its cross-term sum, or loses a carry between halves, shows up there as a product short by a power of two. All-ones operands make every carry chain ripple its full length. An error in the carry out of the second adder, or in how the carries are joined, shows as a wrong top byte for that pair. Walking-one and random 16-bit pairs, operand swaps and operand values of zero and one catch bits that are stuck or misrouted: a cross product wired to the wrong half or shifted by the wrong amount gives an asymmetric or scaled result.

// File: rtl/vc_mult_pkg.sv
package vc_mult_pkg;
  function automatic bit vc_is_pow2(input int n);
    return (n >= 2) && ((n & (n - 1)) == 0);
  endfunction

  function automatic int vc_levels(input int n);
    int k;
    k = 0;
    while ((1 << (k + 1)) <= n) k++;
    return k;
  endfunction
endpackage

// File: rtl/vc_half_add.sv
module vc_half_add (
  input  logic x,
  input  logic y,
  output logic s,
  output logic c
);
  assign s = x ^ y;
  assign c = x & y;
endmodule

// File: rtl/vc_cell2x2.sv
module vc_cell2x2 (
  input  logic [1:0] a,
  input  logic [1:0] b,
  output logic [3:0] p
);
  logic t00, t01, t10, t11;
  logic s1, c1, s2, c2;

  assign t00 = a[0] & b[0];
  assign t10 = a[1] & b[0];
  assign t01 = a[0] & b[1];
  assign t11 = a[1] & b[1];

  vc_half_add u_cross (.x(t10), .y(t01), .s(s1), .c(c1));
  vc_half_add u_top   (.x(c1),  .y(t11), .s(s2), .c(c2));

  assign p = {c2, s2, s1, t00};
endmodule

// File: rtl/vc_ripple_add.sv
module vc_ripple_add #(
  parameter int W = 8
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] s,
  output logic         co
);
  logic [W:0] cy;
  assign cy[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_fa
    logic hx;
    assign hx       = x[i] ^ y[i];
    assign s[i]     = hx ^ cy[i];
    assign cy[i+1]  = (x[i] & y[i]) | (hx & cy[i]);
  end

  assign co = cy[W];
endmodule

// File: rtl/vc_level.sv
module vc_level #(
  parameter int N = 16
) (
  input  logic [N-1:0]   a,
  input  logic [N-1:0]   b,
  output logic [2*N-1:0] p
);
  localparam int H = N / 2;

  if (N == 2) begin : g_leaf
    vc_cell2x2 u_cell (.a(a), .b(b), .p(p));
  end else begin : g_split
    logic [N-1:0] p_ll, p_lh, p_hl, p_hh;
    logic [N-1:0] cross_s, mid_s, top_s, mid_add, top_add;
    logic         cross_c, mid_c, top_c;

    vc_level #(.N(H)) u_ll (.a(a[H-1:0]), .b(b[H-1:0]), .p(p_ll));
    vc_level #(.N(H)) u_lh (.a(a[H-1:0]), .b(b[N-1:H]), .p(p_lh));
    vc_level #(.N(H)) u_hl (.a(a[N-1:H]), .b(b[H-1:0]), .p(p_hl));
    vc_level #(.N(H)) u_hh (.a(a[N-1:H]), .b(b[N-1:H]), .p(p_hh));

    // cross terms
    vc_ripple_add #(.W(N)) u_add_cross (
      .x(p_lh), .y(p_hl), .s(cross_s), .co(cross_c));

    // fold in the upper half of the low-by-low term
    assign mid_add = {{H{1'b0}}, p_ll[N-1:H]};
    vc_ripple_add #(.W(N)) u_add_mid (
      .x(cross_s), .y(mid_add), .s(mid_s), .co(mid_c));

    // the combined middle sum is below 2^(N+1): at most one carry is set
    assign top_add = {{(H-1){1'b0}}, cross_c | mid_c, mid_s[N-1:H]};
    vc_ripple_add #(.W(N)) u_add_top (
      .x(p_hh), .y(top_add), .s(top_s), .co(top_c));

    assign p = {top_s, mid_s[H-1:0], p_ll[H-1:0]};

    logic unused_top_c;
    assign unused_top_c = top_c;
  end
endmodule

// File: rtl/vc_mult16.sv
module vc_mult16 #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0]   op_a,
  input  logic [WIDTH-1:0]   op_b,
  output logic [2*WIDTH-1:0] product
);
  import vc_mult_pkg::*;

  localparam int PW     = 2 * WIDTH;
  localparam int LEVELS = vc_levels(WIDTH);

  if (!vc_is_pow2(WIDTH) || LEVELS < 1) begin : g_bad_width
    $error("vc_mult16: WIDTH must be a power of two, at least 2");
  end

  logic [PW-1:0] prod_w;

  vc_level #(.N(WIDTH)) u_root (.a(op_a), .b(op_b), .p(prod_w));

  assign product = prod_w;
endmodule

// File: rtl/vc_mult16_chk.sv
module vc_mult16_chk #(
  parameter int WIDTH = 16
) (
  input logic [WIDTH-1:0]   op_a,
  input logic [WIDTH-1:0]   op_b,
  input logic [2*WIDTH-1:0] product
);
  localparam int PW = 2 * WIDTH;
  localparam int H  = WIDTH / 2;

  always_comb begin
    if (!$isunknown({op_a, op_b})) begin
      assert_exact_product_R1: assert (product == PW'(op_a) * PW'(op_b))
        else $error("R1 product mismatch");
      assert_zero_operand_R3: assert (!((op_a == '0) || (op_b == '0)) || (product == '0))
        else $error("R3 zero operand gave nonzero product");
      assert_unit_operand_R4: assert (!(op_a == WIDTH'(1)) || (product == PW'(op_b)))
        else $error("R4 unit operand");
      assert_lsb_and_R5: assert (product[0] == (op_a[0] & op_b[0]))
        else $error("R5 product LSB");
      assert_narrow_upper_zero_R8: assert (!((op_a >> H) == '0 && (op_b >> H) == '0)
                                           || (product[PW-1:WIDTH] == '0))
        else $error("R8 upper half not zero");
    end
  end
endmodule

bind vc_mult16 vc_mult16_chk #(.WIDTH(WIDTH)) u_chk (
  .op_a(op_a), .op_b(op_b), .product(product));

// File: tb/tb_vc_mult16.sv
module tb_vc_mult16;
  localparam int W  = 16;
  localparam int PW = 2 * W;

  logic clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic [W-1:0]  a, b;
  logic [PW-1:0] p;
  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 1'b0;

  vc_mult16 #(.WIDTH(W)) dut (.op_a(a), .op_b(b), .product(p));

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (!done && cycles > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run did not complete, actual cycles %0d expected < 150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic expect_eq(input string req, input logic [PW-1:0] act, input logic [PW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: a=%0h b=%0h actual %0h expected %0h", req, a, b, act, exp);
    end
  endtask

  task automatic apply(input logic [W-1:0] x, input logic [W-1:0] y);
    a = x; b = y;
    #1;
  endtask

  task automatic t_initial();
    apply('0, '0);
    expect_eq("R3", p, '0);
  endtask

  task automatic t_known();
    apply(16'd325, 16'd512); expect_eq("R7", p, 32'd166400);
    apply(16'd24, 16'd24);   expect_eq("R7", p, 32'd576);
    apply(16'hFFFF, 16'hFFFF); expect_eq("R6", p, 32'hFFFE0001);
  endtask

  task automatic t_zero_one();
    apply(16'hBEEF, '0); expect_eq("R3", p, '0);
    apply('0, 16'hFFFF); expect_eq("R3", p, '0);
    apply(16'd1, 16'hA5C3); expect_eq("R4", p, 32'h0000A5C3);
    apply(16'hFFFF, 16'd1); expect_eq("R4", p, 32'h0000FFFF);
    apply(16'd1, 16'd1);    expect_eq("R4", p, 32'd1);
  endtask

  task automatic t_exhaustive8();
    for (int i = 0; i < 256; i++) begin
      for (int j = 0; j < 256; j++) begin
        apply(W'(i), W'(j));
        expect_eq("R8", p, PW'(i * j));
      end
    end
  endtask

  task automatic t_walking();
    for (int i = 0; i < W; i++) begin
      for (int j = 0; j < W; j++) begin
        apply(W'(1) << i, W'(1) << j);
        expect_eq("R1", p, PW'(1) << (i + j));
        expect_eq("R5", {{(PW-1){1'b0}}, p[0]}, PW'((i == 0) && (j == 0)));
      end
    end
  endtask

  task automatic t_random();
    for (int k = 0; k < 4000; k++) begin
      logic [W-1:0] x, y;
      logic [PW-1:0] ref_p;
      x = W'($urandom);
      y = W'($urandom);
      ref_p = PW'(x) * PW'(y);
      apply(x, y);
      expect_eq("R1", p, ref_p);
      apply(y, x);
      expect_eq("R9", p, ref_p);
    end
  endtask

  task automatic t_no_state();
    // same operands after very different history must give the same result
    apply(16'hFFFF, 16'hFFFF);
    apply(16'h1234, 16'h00FF);
    expect_eq("R2", p, 32'h1234 * 32'hFF);
    apply(16'h0000, 16'h0000);
    apply(16'h1234, 16'h00FF);
    expect_eq("R2", p, 32'h1234 * 32'hFF);
    a = 16'h8001; b = 16'h8001;
    #1;
    expect_eq("R2", p, 32'h40010001);
  endtask

  initial begin
    t_initial();
    t_known();
    t_zero_one();
    t_no_state();
    t_walking();
    t_exhaustive8();
    t_random();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule